// File: doc/BRIEF.md
# Buck Converter Overvoltage/Undervoltage Fault Sequencer

This block sequences the output-voltage faults of a synchronous buck regulator. Pre-digitized comparator flags report whether the feedback voltage sits below the undervoltage trip level (79 % of reference), above the power-good rising level (91 %) or above the overvoltage level (116 % of the final reference). From these flags, plus the enable, a soft-start-complete flag, a negative-current-limit flag and an on-time-expired flag, it decides who drives the two power switches. It also decides when to restart soft start.

In normal operation the gate commands of the regulation loop pass straight through. An overvoltage latches a discharge routine. In that routine the low-side switch is held on until the negative current limit trips, then the high-side switch gets one on-time pulse, and this repeats until feedback falls below the undervoltage level. An undervoltage that persists for a programmable delay puts the converter into hiccup. In hiccup both switches stay off for seven soft-start periods, and then a fresh soft start is requested.

Top module: `ovuv_fault_ctrl`

## Requirements
- R1: While reset is high, or while `en` is low, the controller is idle. `hs_on`, `ls_on`, `ss_restart`, `ov_flag` and `hiccup_flag` are all 0.
- R2: On the first clock edge with `en` high in idle, the controller enters run mode and `ss_restart` is high for exactly one cycle. In run mode, `hs_on` follows `norm_hs` and `ls_on` follows `norm_ls`.
- R3: While `ss_done` is low, no undervoltage condition can lead to hiccup.
- R4: With `ss_done` high and the trip latch clear, `fb_below_uv` held high makes `hiccup_flag` rise on the (UV_DLY_CYC+1)-th clock edge. One edge sets the trip latch and UV_DLY_CYC edges are counted.
- R5: Once tripped, the delay keeps counting while feedback sits between the two levels (both flags low). Only `fb_above_pg` clears the trip and zeroes the count, and a new trip starts the full delay again.
- R6: After enable or restart the trip latch starts set. If `fb_above_pg` has not been seen, the delay counts once `ss_done` is high, and hiccup follows after UV_DLY_CYC edges.
- R7: Hiccup holds both gates low for exactly 7*SS_CYC cycles. It then returns to run mode, pulses `ss_restart` for one cycle and clears the overvoltage latch.
- R8: `fb_above_ov` in run mode latches `ov_flag` whether or not soft start is done. After the latching edge there is one cycle with both gates low, then `ls_on` is high and `hs_on` is low, regardless of the normal commands. A prebiased overvoltage present at enable is acted on in the first run cycle.
- R9: In the discharge loop, `neg_ilim` ends the low-side phase. One cycle with both gates low follows, then `hs_on` is high until `ton_done`. Another both-low cycle follows, then the low-side phase resumes. The latch holds even after `fb_above_ov` falls.
- R10: `fb_below_uv` during discharge stops the loop with both gates low and `ov_flag` still high. The undervoltage delay then runs once `ss_done` is high, and leads to hiccup.
- R11: Dropping `en` returns to idle on the next edge and clears the overvoltage latch and all timers.
- R12: `hs_on` and `ls_on` are never high together; conflicting normal commands yield both low. If `fb_above_pg` is high in the cycle the delay would expire, the recovery wins and no hiccup occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Output enable |
| ss_done | input | 1 | Soft-start ramp complete |
| fb_below_uv | input | 1 | Feedback below undervoltage trip level |
| fb_above_pg | input | 1 | Feedback above power-good rising level |
| fb_above_ov | input | 1 | Feedback above overvoltage level |
| neg_ilim | input | 1 | Low-side negative current limit reached |
| ton_done | input | 1 | On-time pulse expired |
| norm_hs | input | 1 | High-side command from regulation loop |
| norm_ls | input | 1 | Low-side command from regulation loop |
| hs_on | output | 1 | High-side gate request |
| ls_on | output | 1 | Low-side gate request |
| ss_restart | output | 1 | One-cycle soft-start restart request |
| ov_flag | output | 1 | Overvoltage latch active |
| hiccup_flag | output | 1 | Hiccup sleep in progress |

## Verification
The undervoltage delay can expire in the same cycle that feedback recovers above the power-good level. The bench provokes this by sweeping the recovery point over every count of the delay, including the count at which expiry would fire. It then judges two things: no hiccup may appear, and a later trip must again take the full UV_DLY_CYC+1 edges to reach hiccup. A second collision is a prebiased overvoltage arriving together with enable. There the bench checks that the restart pulse and the overvoltage latch appear on consecutive edges, with a both-off cycle before the low-side phase.

// File: rtl/ovuv_pkg.sv
package ovuv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_OV_GAP_L,
        ST_OV_LS,
        ST_OV_GAP_H,
        ST_OV_HS,
        ST_OV_HOLD,
        ST_HICCUP
    } ovuv_state_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    localparam int SLEEP_MULT = 7;

    function automatic logic in_ov(input ovuv_state_e s);
        return (s == ST_OV_GAP_L) || (s == ST_OV_LS) || (s == ST_OV_GAP_H) ||
               (s == ST_OV_HS) || (s == ST_OV_HOLD);
    endfunction

    function automatic logic uv_window(input ovuv_state_e s);
        return (s == ST_RUN) || (s == ST_OV_HOLD);
    endfunction

endpackage

// File: rtl/ovuv_uv_timer.sv
module ovuv_uv_timer #(
    parameter int UV_DLY_CYC = 14000
) (
    input  logic clk,
    input  logic rst,
    input  logic rearm,
    input  logic window,
    input  logic ss_done,
    input  logic fb_below_uv,
    input  logic fb_above_pg,
    output logic expire
);
    localparam int CW = $clog2(UV_DLY_CYC + 1);

    logic          tripped;
    logic [CW-1:0] cnt;
    logic          active;

    assign active = tripped && !fb_above_pg && ss_done && window && !rearm;
    assign expire = active && (cnt == CW'(UV_DLY_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            tripped <= 1'b1;
        end else if (fb_above_pg) begin
            tripped <= 1'b0;
        end else if (fb_below_uv) begin
            tripped <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_no_expire_in_soft_start: assert property (@(posedge clk) disable iff (rst)
        !ss_done |-> !expire);

    a_r5_recovery_zeroes_count: assert property (@(posedge clk) disable iff (rst)
        fb_above_pg |=> (cnt == '0));

endmodule

// File: rtl/ovuv_sleep_timer.sv
module ovuv_sleep_timer #(
    parameter int SS_CYC = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int SLEEP = ovuv_pkg::SLEEP_MULT * SS_CYC;
    localparam int CW    = $clog2(SLEEP + 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(SLEEP - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= CW'(SLEEP - 1)));

endmodule

// File: rtl/ovuv_gate_drive.sv
module ovuv_gate_drive
    import ovuv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ovuv_state_e state,
    input  logic        norm_hs,
    input  logic        norm_ls,
    output logic        hs_on,
    output logic        ls_on
);
    gate_pair_t g;

    always_comb begin
        g = '0;
        unique case (state)
            ST_RUN: begin
                g.hs = norm_hs && !norm_ls;
                g.ls = norm_ls && !norm_hs;
            end
            ST_OV_LS: g.ls = 1'b1;
            ST_OV_HS: g.hs = 1'b1;
            default:  g = '0;
        endcase
    end

    assign hs_on = g.hs;
    assign ls_on = g.ls;

    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hs_on && ls_on));

    a_r9_hs_dead_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_ov(state) && $rose(hs_on)) |-> $past(!ls_on));

    a_r9_ls_dead_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_ov(state) && $rose(ls_on)) |-> $past(!hs_on));

endmodule

// File: rtl/ovuv_fault_ctrl.sv
module ovuv_fault_ctrl
    import ovuv_pkg::*;
#(
    parameter int UV_DLY_CYC = 14000,
    parameter int SS_CYC     = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ss_done,
    input  logic fb_below_uv,
    input  logic fb_above_pg,
    input  logic fb_above_ov,
    input  logic neg_ilim,
    input  logic ton_done,
    input  logic norm_hs,
    input  logic norm_ls,
    output logic hs_on,
    output logic ls_on,
    output logic ss_restart,
    output logic ov_flag,
    output logic hiccup_flag
);
    ovuv_state_e state, nxt;
    logic        uv_expire;
    logic        sleep_done;
    logic        rearm;
    logic        restart_d;

    assign rearm = (state == ST_IDLE) || (state == ST_HICCUP);

    ovuv_uv_timer #(.UV_DLY_CYC(UV_DLY_CYC)) uv_i (
        .clk        (clk),
        .rst        (rst),
        .rearm      (rearm),
        .window     (uv_window(state)),
        .ss_done    (ss_done),
        .fb_below_uv(fb_below_uv),
        .fb_above_pg(fb_above_pg),
        .expire     (uv_expire)
    );

    ovuv_sleep_timer #(.SS_CYC(SS_CYC)) sleep_i (
        .clk (clk),
        .rst (rst),
        .run (state == ST_HICCUP),
        .done(sleep_done)
    );

    ovuv_gate_drive gate_i (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .norm_hs(norm_hs),
        .norm_ls(norm_ls),
        .hs_on  (hs_on),
        .ls_on  (ls_on)
    );

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_RUN;
                ST_RUN: begin
                    if (uv_expire)        nxt = ST_HICCUP;
                    else if (fb_above_ov) nxt = ST_OV_GAP_L;
                end
                ST_OV_GAP_L: nxt = fb_below_uv ? ST_OV_HOLD : ST_OV_LS;
                ST_OV_LS: begin
                    if (fb_below_uv)   nxt = ST_OV_HOLD;
                    else if (neg_ilim) nxt = ST_OV_GAP_H;
                end
                ST_OV_GAP_H: nxt = fb_below_uv ? ST_OV_HOLD : ST_OV_HS;
                ST_OV_HS: begin
                    if (fb_below_uv)   nxt = ST_OV_HOLD;
                    else if (ton_done) nxt = ST_OV_GAP_L;
                end
                ST_OV_HOLD:  if (uv_expire)  nxt = ST_HICCUP;
                ST_HICCUP:   if (sleep_done) nxt = ST_RUN;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    assign restart_d = en && ((state == ST_IDLE) || (state == ST_HICCUP && sleep_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ss_restart <= 1'b0;
        end else begin
            state      <= nxt;
            ss_restart <= restart_d;
        end
    end

    assign ov_flag     = in_ov(state);
    assign hiccup_flag = (state == ST_HICCUP);

    a_r11_disable_to_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ov_flag && !hiccup_flag && !hs_on && !ls_on));

    a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (ov_flag && en) |=> (ov_flag || hiccup_flag));

    a_r2_restart_single: assert property (@(posedge clk) disable iff (rst)
        ss_restart |=> !ss_restart);

    a_r7_hiccup_gates_off: assert property (@(posedge clk) disable iff (rst)
        hiccup_flag |-> (!hs_on && !ls_on));

endmodule

// File: tb/ovuv_fault_ctrl_tb_top.sv
module ovuv_fault_ctrl_tb_top;
    localparam int UVD   = 8;
    localparam int SSC   = 4;
    localparam int SLEEP = 7 * SSC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, ss_done = 0, fb_below_uv = 0, fb_above_pg = 0, fb_above_ov = 0;
    logic neg_ilim = 0, ton_done = 0, norm_hs = 0, norm_ls = 0;
    logic hs_on, ls_on, ss_restart, ov_flag, hiccup_flag;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ovuv_fault_ctrl #(.UV_DLY_CYC(UVD), .SS_CYC(SSC)) dut_i (
        .clk(clk), .rst(rst), .en(en), .ss_done(ss_done),
        .fb_below_uv(fb_below_uv), .fb_above_pg(fb_above_pg), .fb_above_ov(fb_above_ov),
        .neg_ilim(neg_ilim), .ton_done(ton_done), .norm_hs(norm_hs), .norm_ls(norm_ls),
        .hs_on(hs_on), .ls_on(ls_on), .ss_restart(ss_restart),
        .ov_flag(ov_flag), .hiccup_flag(hiccup_flag)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges_to_hiccup(output int n);
        n = 0;
        while (!hiccup_flag && n < 100) begin
            tick();
            n++;
        end
    endtask

    task automatic ride_hiccup(output int n);
        n = 0;
        ss_done = 0; fb_below_uv = 0; fb_above_pg = 1;
        while (hiccup_flag && n < 100) begin
            tick();
            n++;
        end
    endtask

    task automatic settle_good();
        int n;
        ride_hiccup(n);
        chk("R7 sleep length", n, SLEEP);
        chk("R7 restart pulse", ss_restart, 1);
        ss_done = 1;
        tick(2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        tick(3);
        chk("R1 hs in reset", hs_on, 0);
        chk("R1 ls in reset", ls_on, 0);
        chk("R1 flags in reset", {ss_restart, ov_flag, hiccup_flag}, 0);
        rst = 0;
        tick(2);
        chk("R1 idle without en", {hs_on, ls_on, ss_restart, ov_flag, hiccup_flag}, 0);

        en = 1;
        tick();
        chk("R2 restart pulse", ss_restart, 1);
        tick();
        chk("R2 pulse ends", ss_restart, 0);
        norm_hs = 1; norm_ls = 0; #1;
        chk("R2 hs follows", {hs_on, ls_on}, 2);
        norm_hs = 0; norm_ls = 1; #1;
        chk("R2 ls follows", {hs_on, ls_on}, 1);
        norm_hs = 1; norm_ls = 1; #1;
        chk("R12 conflict masked", {hs_on, ls_on}, 0);
        norm_hs = 0; norm_ls = 0;

        fb_below_uv = 1;
        tick(40);
        chk("R3 no hiccup in soft start", hiccup_flag, 0);

        fb_below_uv = 0; fb_above_pg = 0; ss_done = 1;
        edges_to_hiccup(n);
        chk("R6 pg never seen", n, UVD);
        norm_hs = 1; #1;
        chk("R7 gates off in hiccup", {hs_on, ls_on}, 0);
        norm_hs = 0;
        settle_good();

        for (int k = 1; k <= UVD; k++) begin
            fb_above_pg = 0; fb_below_uv = 1;
            tick(k);
            chk("R5 no hiccup before recovery", hiccup_flag, 0);
            fb_below_uv = 0; fb_above_pg = 1;
            tick();
            chk("R12 recovery wins", hiccup_flag, 0);
            tick();
            fb_above_pg = 0; fb_below_uv = 1;
            edges_to_hiccup(n);
            chk("R4 full delay after recovery", n, UVD + 1);
            settle_good();
        end

        fb_above_pg = 0; fb_below_uv = 1;
        tick(3);
        fb_below_uv = 0;
        edges_to_hiccup(n);
        chk("R5 counts in band", n, UVD + 1 - 3);
        settle_good();

        en = 0; norm_hs = 1;
        tick();
        chk("R11 idle on disable", {hs_on, ls_on, ov_flag, hiccup_flag}, 0);
        ss_done = 0; fb_above_ov = 1; fb_above_pg = 1; fb_below_uv = 0; en = 1;
        tick();
        chk("R8 restart before ov", {ss_restart, ov_flag}, 2);
        tick();
        chk("R8 ov latched in soft start", ov_flag, 1);
        chk("R8 entry gap", {hs_on, ls_on}, 0);
        tick();
        chk("R8 low side on", {hs_on, ls_on}, 1);
        fb_above_ov = 0;
        tick(5);
        chk("R9 latch holds", {ov_flag, hs_on, ls_on}, 5);
        neg_ilim = 1;
        tick();
        neg_ilim = 0;
        chk("R9 gap after nil", {hs_on, ls_on}, 0);
        tick();
        chk("R9 hs pulse", {hs_on, ls_on}, 2);
        tick(3);
        chk("R9 hs until ton", {hs_on, ls_on}, 2);
        ton_done = 1;
        tick();
        ton_done = 0;
        chk("R9 gap after ton", {hs_on, ls_on}, 0);
        tick();
        chk("R9 ls resumes", {hs_on, ls_on}, 1);

        fb_below_uv = 1; fb_above_pg = 0;
        tick();
        chk("R10 hold both off", {ov_flag, hs_on, ls_on}, 4);
        tick(30);
        chk("R10 waits for ss_done", {ov_flag, hiccup_flag}, 2);
        ss_done = 1;
        edges_to_hiccup(n);
        chk("R10 uv delay after discharge", n, UVD);
        chk("R7 ov cleared by hiccup", ov_flag, 0);
        settle_good();

        fb_above_ov = 1;
        tick(2);
        chk("R8 ov after soft start", {ov_flag, ls_on}, 3);
        fb_above_ov = 0; en = 0;
        tick();
        chk("R11 latch cleared", {ov_flag, hs_on, ls_on}, 0);
        en = 1;
        tick(2);
        chk("R11 run without latch", {ov_flag, hs_on}, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule